// File: doc/BRIEF.md
# Byte Rotate, Shift and Bit-Test Unit

This unit carries out the single-operand byte operations of an 8-bit processor datapath: four rotates, four shifts and a single-bit test. Each request presents an operand byte, the current flag byte, an operation code and a bit index. One clock later the unit returns the new byte, the new flag byte and a write strobe. The strobe tells the surrounding datapath whether the byte should be stored back to the register or memory location it came from.

The operand and the flags arrive already fetched, and the unit does no fetching of its own. The results are registered, so the unit fits one pipeline stage. The flag byte uses a fixed layout because downstream condition logic decodes it: bit 7 sign, bit 6 zero, bit 4 half-carry, bit 2 parity/overflow, bit 1 subtract, bit 0 carry. Bits 5 and 3 are spare and are carried through.

Top module: `rsb_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `result`, `flags_out` and `wr_en` all become zero on that edge.
- R2: A request with `in_valid` high is answered on the next clock edge with `out_valid` high. `out_valid` is low after any edge where `in_valid` was low.
- R3: The through-carry rotates work as follows. `op`=2 (left) shifts the byte left, puts the incoming carry (flag bit 0) into bit 0 and moves the old bit 7 into carry. `op`=3 (right) shifts the byte right, puts the incoming carry into bit 7 and moves the old bit 0 into carry.
- R4: The circular rotates work as follows. `op`=0 (left) copies old bit 7 into both bit 0 and carry. `op`=1 (right) copies old bit 0 into both bit 7 and carry.
- R5: The right shifts work as follows. `op`=5 (arithmetic) keeps bit 7 unchanged. `op`=7 (logical) fills bit 7 with zero. Both move old bit 0 into carry.
- R6: The left shifts work as follows. `op`=4 fills bit 0 with zero and `op`=6 fills bit 0 with one. Both move old bit 7 into carry.
- R7: For `op` 0 to 7, half-carry (bit 4) and subtract (bit 1) are cleared. Zero (bit 6) is set when the result is 0x00. Sign (bit 7) equals result bit 7. Parity (bit 2) is set when the result has an even number of ones.
- R8: Bit test (`op`=8) works on the operand bit chosen by `bit_idx`. Zero is set when that bit is 0. Half-carry is set, subtract is cleared and carry keeps its incoming value.
- R9: On bit test, parity equals the new zero flag. Sign is set only when `bit_idx`=7 and operand bit 7 is 1.
- R10: Flag bits 5 and 3 are always copied from `flags_in`. Unused codes (`op` 9 to 15) return the operand and `flags_in` unchanged.
- R11: `wr_en` is high for `op` 0 to 7. It is low for bit test and for unused codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Operation code |
| bit_idx | input | 3 | Bit index for bit test |
| operand | input | 8 | Operand byte |
| flags_in | input | 8 | Incoming flag byte |
| out_valid | output | 1 | Result strobe, one cycle after request |
| result | output | 8 | Result byte |
| flags_out | output | 8 | Updated flag byte |
| wr_en | output | 1 | Store-back strobe |

## Verification
Every result is due exactly one clock edge after its request is sampled: the byte, the flags and the write strobe are all due on that edge. The driver applies a request on a falling edge and queues the expected answer at the same moment. The monitor samples on the following falling edge and pops one entry for each `out_valid` it sees. A strobe that arrives early, late or without a queued request is counted as a timing failure under R2. Idle gaps between bursts confirm that no extra results appear.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  localparam int FLAG_W = 8;
  localparam int F_S  = 7;
  localparam int F_Z  = 6;
  localparam int F_H  = 4;
  localparam int F_PV = 2;
  localparam int F_N  = 1;
  localparam int F_C  = 0;

  typedef enum logic [3:0] {
    OP_ROTL_CIRC  = 4'd0,
    OP_ROTR_CIRC  = 4'd1,
    OP_ROTL_CARRY = 4'd2,
    OP_ROTR_CARRY = 4'd3,
    OP_SHL_ZERO   = 4'd4,
    OP_SHR_ARITH  = 4'd5,
    OP_SHL_ONE    = 4'd6,
    OP_SHR_LOGIC  = 4'd7,
    OP_BIT_TEST   = 4'd8
  } rsb_op_e;
endpackage

// File: rtl/rsb_shift_core.sv
module rsb_shift_core #(
  parameter int W = 8
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] din,
  input  logic         carry_in,
  output logic [W-1:0] dout,
  output logic         carry_out,
  output logic         is_shift
);
  import rsb_pkg::*;

  logic fill_lo;
  logic fill_hi;
  logic to_left;

  always_comb begin
    fill_lo  = 1'b0;
    fill_hi  = 1'b0;
    to_left  = 1'b0;
    is_shift = 1'b1;
    case (op)
      OP_ROTL_CIRC:  begin to_left = 1'b1; fill_lo = din[W-1]; end
      OP_ROTR_CIRC:  begin fill_hi = din[0]; end
      OP_ROTL_CARRY: begin to_left = 1'b1; fill_lo = carry_in; end
      OP_ROTR_CARRY: begin fill_hi = carry_in; end
      OP_SHL_ZERO:   begin to_left = 1'b1; end
      OP_SHR_ARITH:  begin fill_hi = din[W-1]; end
      OP_SHL_ONE:    begin to_left = 1'b1; fill_lo = 1'b1; end
      OP_SHR_LOGIC:  begin fill_hi = 1'b0; end
      default:       is_shift = 1'b0;
    endcase
    if (to_left) begin
      dout      = {din[W-2:0], fill_lo};
      carry_out = din[W-1];
    end else begin
      dout      = {fill_hi, din[W-1:1]};
      carry_out = din[0];
    end
  end
endmodule

// File: rtl/rsb_bit_test.sv
module rsb_bit_test #(
  parameter int W     = 8,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     din,
  input  logic [IDX_W-1:0] idx,
  output logic             bit_set,
  output logic             top_hit
);
  logic [W-1:0] sel_mask;

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_mask
      assign sel_mask[g] = (idx == IDX_W'(g)) & din[g];
    end
  endgenerate

  assign bit_set = |sel_mask;
  assign top_hit = sel_mask[W-1];
endmodule

// File: rtl/rsb_unit.sv
module rsb_unit #(
  parameter int W     = 8,
  parameter int IDX_W = $clog2(W)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [3:0]                op,
  input  logic [IDX_W-1:0]          bit_idx,
  input  logic [W-1:0]              operand,
  input  logic [rsb_pkg::FLAG_W-1:0] flags_in,
  output logic                      out_valid,
  output logic [W-1:0]              result,
  output logic [rsb_pkg::FLAG_W-1:0] flags_out,
  output logic                      wr_en
);
  import rsb_pkg::*;

  logic [W-1:0]      sh_val;
  logic              sh_carry;
  logic              sh_sel;
  logic              bt_set;
  logic              bt_top;
  logic [W-1:0]      nxt_val;
  logic [FLAG_W-1:0] nxt_flags;
  logic              nxt_wr;

  rsb_shift_core #(.W(W)) u_shift (
    .op(op), .din(operand), .carry_in(flags_in[F_C]),
    .dout(sh_val), .carry_out(sh_carry), .is_shift(sh_sel)
  );

  rsb_bit_test #(.W(W), .IDX_W(IDX_W)) u_bit (
    .din(operand), .idx(bit_idx), .bit_set(bt_set), .top_hit(bt_top)
  );

  always_comb begin
    nxt_val   = operand;
    nxt_flags = flags_in;
    nxt_wr    = 1'b0;
    if (sh_sel) begin
      nxt_val         = sh_val;
      nxt_wr          = 1'b1;
      nxt_flags[F_C]  = sh_carry;
      nxt_flags[F_N]  = 1'b0;
      nxt_flags[F_H]  = 1'b0;
      nxt_flags[F_Z]  = (sh_val == '0);
      nxt_flags[F_S]  = sh_val[W-1];
      nxt_flags[F_PV] = ~^sh_val;
    end else if (op == OP_BIT_TEST) begin
      nxt_flags[F_Z]  = ~bt_set;
      nxt_flags[F_PV] = ~bt_set;
      nxt_flags[F_H]  = 1'b1;
      nxt_flags[F_N]  = 1'b0;
      nxt_flags[F_S]  = bt_top;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      flags_out <= '0;
      wr_en     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= nxt_val;
        flags_out <= nxt_flags;
        wr_en     <= nxt_wr;
      end
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_spare_bits_R10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (flags_out[5] == $past(flags_in[5])) && (flags_out[3] == $past(flags_in[3])));
  assert_bit_no_write_R11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_BIT_TEST) |=> !wr_en);
  assert_bit_keeps_carry_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_BIT_TEST) |=> (flags_out[F_C] == $past(flags_in[F_C])) && flags_out[F_H]);
  assert_shift_clears_hn_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op < 4'd8) |=> (!flags_out[F_H] && !flags_out[F_N] && wr_en));
  assert_unused_passes_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op > 4'd8) |=> (result == $past(operand)) && (flags_out == $past(flags_in)));
endmodule

// File: tb/rsb_unit_bench.sv
module rsb_unit_bench;
  typedef struct {
    logic [7:0] res;
    logic [7:0] flg;
    logic       wr;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [3:0] op = '0;
  logic [2:0] bit_idx = '0;
  logic [7:0] operand = '0;
  logic [7:0] flags_in = '0;
  logic       out_valid;
  logic [7:0] result;
  logic [7:0] flags_out;
  logic       wr_en;

  exp_t sb_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  rsb_unit u_rsb_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .bit_idx(bit_idx),
    .operand(operand), .flags_in(flags_in), .out_valid(out_valid),
    .result(result), .flags_out(flags_out), .wr_en(wr_en)
  );

  function automatic exp_t model(input logic [3:0] o, input logic [2:0] ix,
                                 input logic [7:0] d, input logic [7:0] f);
    exp_t e;
    logic [7:0] r;
    logic c;
    e.res = d; e.flg = f; e.wr = 1'b0; e.tag = "R10";
    r = d; c = f[0];
    case (o)
      4'd0: begin r = {d[6:0], d[7]}; c = d[7]; e.tag = "R4"; end
      4'd1: begin r = {d[0], d[7:1]}; c = d[0]; e.tag = "R4"; end
      4'd2: begin r = {d[6:0], f[0]}; c = d[7]; e.tag = "R3"; end
      4'd3: begin r = {f[0], d[7:1]}; c = d[0]; e.tag = "R3"; end
      4'd4: begin r = d << 1;          c = d[7]; e.tag = "R6"; end
      4'd5: begin r = {d[7], d[7:1]}; c = d[0]; e.tag = "R5"; end
      4'd6: begin r = (d << 1) | 8'h01; c = d[7]; e.tag = "R6"; end
      4'd7: begin r = d >> 1;          c = d[0]; e.tag = "R5"; end
      default: ;
    endcase
    if (o < 4'd8) begin
      int ones = 0;
      for (int k = 0; k < 8; k++) ones += r[k];
      e.res = r; e.wr = 1'b1;
      e.flg = {r[7], (r == 8'h00), f[5], 1'b0, f[3], (ones % 2 == 0), 1'b0, c};
    end else if (o == 4'd8) begin
      logic z;
      z = ~d[ix];
      e.tag = "R8/R9";
      e.flg = {(ix == 3'd7) && d[7], z, f[5], 1'b1, f[3], z, 1'b0, f[0]};
    end
    return e;
  endfunction

  task automatic send(input logic [3:0] o, input logic [2:0] ix,
                      input logic [7:0] d, input logic [7:0] f);
    @(negedge clk);
    in_valid = 1'b1; op = o; bit_idx = ix; operand = d; flags_in = f;
    sb_q.push_back(model(o, ix, d, f));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (sb_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: out_valid=1 expected 0 (no pending request)");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (result !== e.res || flags_out !== e.flg || wr_en !== e.wr) begin
          errors++;
          $display("FAIL %s/R7/R11: res=%h flg=%b wr=%b expected res=%h flg=%b wr=%b",
                   e.tag, result, flags_out, wr_en, e.res, e.flg, e.wr);
        end
      end
    end
  end

  initial begin
    fork
      begin
        logic [7:0] pats [6] = '{8'h00, 8'h01, 8'h80, 8'hA5, 8'h7E, 8'hFF};
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || result !== 8'h00 || flags_out !== 8'h00 || wr_en !== 1'b0) begin
          errors++;
          $display("FAIL R1: out=%b res=%h flg=%h wr=%b expected all zero",
                   out_valid, result, flags_out, wr_en);
        end
        rst = 1'b0;
        // R3 R4 R5 R6 R7: every shift form, several patterns, both carries
        for (int o = 0; o < 8; o++)
          for (int p = 0; p < 6; p++) begin
            send(4'(o), 3'd0, pats[p], 8'h00);
            send(4'(o), 3'd0, pats[p], 8'h3D);
          end
        idle(3);
        // R8 R9: bit test over every index
        for (int ix = 0; ix < 8; ix++) begin
          send(4'd8, 3'(ix), 8'hA5, 8'hC7);
          send(4'd8, 3'(ix), 8'h5A, 8'h28);
          send(4'd8, 3'(ix), 8'h80, 8'h01);
        end
        idle(2);
        // R10 R11: unused codes pass through without a write
        for (int o = 9; o < 16; o++) send(4'(o), 3'd5, 8'h96, 8'hE9);
        idle(4);
        // R2: single isolated request
        send(4'd7, 3'd0, 8'h02, 8'h00);
        idle(3);
        checks++;
        if (sb_q.size() != 0) begin
          errors++;
          $display("FAIL R2: pending=%0d expected 0", sb_q.size());
        end
        done = 1'b1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL R2: watchdog expired, done=0 expected 1");
        end
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule